// File: doc/BRIEF.md
# Windowed RAM Address Generator

This block produces the column (X) and line (Y) address that a host uses for each access to a display memory. The host programs a rectangular window through a single load port: a select code names one of four window corners (X start, X end, Y start, Y end) and a data word carries the value. Values beyond the memory edge are clamped to the last valid column or line. Loading a start point also moves the current address to that point.

Each access that goes ahead advances the column. When the column reaches the window's end column, it returns to the start column and the line steps. When the line is at the window's end line, it returns to the start line. A level input mirrors the column presented to the memory, so that the panel's segment order can be reversed without changing the host's address sequence. Any window load arms a dummy-read stage. The first read after a load only primes the read path: it returns no valid data and does not move the address. Later reads return valid data and advance.

Top module: `win_addr_gen`

## Requirements
- R1: After reset the current address is column 0, line 0, and the window covers the whole memory (columns 0..2^X_BITS-1, lines 0..Y_LINES-1). The first read after reset is a dummy read.
- R2: A load with select 0 (X start) or select 2 (Y start) stores the clamped value as the window start and moves the current column or line to it on the next cycle. The clamp limit is 2^X_BITS-1 for columns and Y_LINES-1 for lines.
- R3: A load with select 1 (X end) or select 3 (Y end) stores the clamped value as the window end and leaves the current address unchanged.
- R4: An advancing access with the current column below the end column increments the column by one and keeps the line.
- R5: An advancing access with the column at or past the end column reloads the start column. The line increments if it is below the end line.
- R6: When the column wraps and the line is at or past the end line, the line reloads the start line.
- R7: The memory column output equals the current column when the reverse input is 0, and 2^X_BITS-1 minus the current column when it is 1, in the same cycle.
- R8: Every load arms the dummy flag. A read while armed clears the flag, does not move the address, and gives rd_valid=0 in the next cycle. A read while not armed advances the address and gives rd_valid=1 in the next cycle.
- R9: Writes always advance, never clear the dummy flag, and give rd_valid=0 in the next cycle.
- R10: A load and an access in the same cycle: the load takes effect and the access is ignored (no advance, no change to the dummy flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_valid | input | 1 | Window load strobe |
| set_sel | input | 2 | Load target: 0 X start, 1 X end, 2 Y start, 3 Y end |
| set_data | input | D_W | Load value, D_W = max(X_BITS, clog2(Y_LINES)) |
| acc_valid | input | 1 | Host access strobe |
| acc_read | input | 1 | 1 = read, 0 = write |
| col_reverse | input | 1 | Mirror the memory column |
| cur_x | output | X_BITS | Current column address |
| cur_y | output | Y_BITS | Current line address |
| ram_col | output | X_BITS | Column presented to memory (mirrored if selected) |
| rd_valid | output | 1 | Previous cycle's read returned valid data |

## Verification
The bench builds the block with X_BITS=4 and Y_LINES=10, so there are 16 columns and 10 lines. With these values the default full-window column wrap takes only 16 accesses. A line count that is not a power of two makes the Y clamp reachable with a 4-bit load word (values 10 to 15 fold to 9). The small window also lets the bench walk a small inner window through both wraps and the mirrored column at the top edge in a few dozen cycles.

// File: rtl/win_addr_pkg.sv
package win_addr_pkg;
  typedef enum logic [1:0] {
    SEL_X_START = 2'd0,
    SEL_X_END   = 2'd1,
    SEL_Y_START = 2'd2,
    SEL_Y_END   = 2'd3
  } win_sel_e;
endpackage

// File: rtl/win_bounds.sv
module win_bounds
  import win_addr_pkg::*;
#(
  parameter int X_BITS = 7,
  parameter int Y_LINES = 162,
  localparam int Y_BITS = $clog2(Y_LINES),
  localparam int D_W = (X_BITS > Y_BITS) ? X_BITS : Y_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [1:0]        set_sel,
  input  logic [D_W-1:0]    set_data,
  output logic [X_BITS-1:0] clamp_x,
  output logic [Y_BITS-1:0] clamp_y,
  output logic [X_BITS-1:0] x_start,
  output logic [X_BITS-1:0] x_end,
  output logic [Y_BITS-1:0] y_start,
  output logic [Y_BITS-1:0] y_end
);
  localparam int XMAX = (1 << X_BITS) - 1;
  localparam int YMAX = Y_LINES - 1;
  localparam logic [D_W-1:0] XMAX_D = D_W'(XMAX);
  localparam logic [D_W-1:0] YMAX_D = D_W'(YMAX);

  logic [X_BITS-1:0] x_start_d, x_end_d;
  logic [Y_BITS-1:0] y_start_d, y_end_d;

  always_comb begin
    clamp_x = (set_data > XMAX_D) ? X_BITS'(XMAX) : set_data[X_BITS-1:0];
    clamp_y = (set_data > YMAX_D) ? Y_BITS'(YMAX) : set_data[Y_BITS-1:0];
  end

  always_comb begin
    x_start_d = x_start;
    x_end_d   = x_end;
    y_start_d = y_start;
    y_end_d   = y_end;
    if (set_valid) begin
      case (win_sel_e'(set_sel))
        SEL_X_START: x_start_d = clamp_x;
        SEL_X_END:   x_end_d   = clamp_x;
        SEL_Y_START: y_start_d = clamp_y;
        default:     y_end_d   = clamp_y;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_start <= '0;
      x_end   <= X_BITS'(XMAX);
      y_start <= '0;
      y_end   <= Y_BITS'(YMAX);
    end else if (set_valid) begin
      x_start <= x_start_d;
      x_end   <= x_end_d;
      y_start <= y_start_d;
      y_end   <= y_end_d;
    end
  end

  a_r3_bounds_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (y_start <= Y_BITS'(YMAX)) && (y_end <= Y_BITS'(YMAX)));
endmodule

// File: rtl/win_cursor.sv
module win_cursor #(
  parameter int X_BITS = 7,
  parameter int Y_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_x,
  input  logic              load_y,
  input  logic [X_BITS-1:0] load_x_val,
  input  logic [Y_BITS-1:0] load_y_val,
  input  logic              step,
  input  logic [X_BITS-1:0] x_start,
  input  logic [X_BITS-1:0] x_end,
  input  logic [Y_BITS-1:0] y_start,
  input  logic [Y_BITS-1:0] y_end,
  output logic [X_BITS-1:0] x_q,
  output logic [Y_BITS-1:0] y_q
);
  logic [X_BITS-1:0] x_d;
  logic [Y_BITS-1:0] y_d;
  logic              x_en, y_en;

  always_comb begin
    x_d  = x_q;
    y_d  = y_q;
    x_en = 1'b0;
    y_en = 1'b0;
    if (load_x || load_y) begin
      x_en = load_x;
      y_en = load_y;
      x_d  = load_x_val;
      y_d  = load_y_val;
    end else if (step) begin
      x_en = 1'b1;
      if (x_q >= x_end) begin
        x_d  = x_start;
        y_en = 1'b1;
        y_d  = (y_q >= y_end) ? y_start : y_q + 1'b1;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_q <= '0;
    else if (x_en) x_q <= x_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else if (y_en) y_q <= y_d;
  end

  a_r4_col_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_x && !load_y && x_q < x_end) |=> (x_q == $past(x_q) + 1'b1) && $stable(y_q));
  a_r5_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_x && !load_y && x_q >= x_end) |=> (x_q == $past(x_start)));
  a_r6_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_x && !load_y && x_q >= x_end && y_q >= y_end) |=> (y_q == $past(y_start)));
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_x && !load_y) |=> $stable(x_q) && $stable(y_q));
endmodule

// File: rtl/win_dummy_ctl.sv
module win_dummy_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_valid,
  input  logic acc_valid,
  input  logic acc_read,
  output logic step,
  output logic rd_valid
);
  logic armed_q, armed_d;
  logic rd_valid_d;
  logic acc_go;

  always_comb begin
    acc_go     = acc_valid && !set_valid;
    step       = acc_go && !(acc_read && armed_q);
    armed_d    = armed_q;
    rd_valid_d = 1'b0;
    if (set_valid) begin
      armed_d = 1'b1;
    end else if (acc_go && acc_read) begin
      armed_d    = 1'b0;
      rd_valid_d = !armed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b1;
      rd_valid <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      rd_valid <= rd_valid_d;
    end
  end

  a_r8_dummy_gives_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_read && !set_valid && armed_q) |=> !rd_valid && !armed_q);
  a_r9_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_read) |=> !rd_valid);
  a_r8_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> armed_q);
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import win_addr_pkg::*;
#(
  parameter int X_BITS = 7,
  parameter int Y_LINES = 162,
  localparam int Y_BITS = $clog2(Y_LINES),
  localparam int D_W = (X_BITS > Y_BITS) ? X_BITS : Y_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [1:0]        set_sel,
  input  logic [D_W-1:0]    set_data,
  input  logic              acc_valid,
  input  logic              acc_read,
  input  logic              col_reverse,
  output logic [X_BITS-1:0] cur_x,
  output logic [Y_BITS-1:0] cur_y,
  output logic [X_BITS-1:0] ram_col,
  output logic              rd_valid
);
  localparam int XMAX = (1 << X_BITS) - 1;

  logic [1:0]        rst_sync;
  logic              rst_n_int;
  logic [X_BITS-1:0] clamp_x, x_start, x_end;
  logic [Y_BITS-1:0] clamp_y, y_start, y_end;
  logic              step;
  logic              load_x, load_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  assign load_x = set_valid && (win_sel_e'(set_sel) == SEL_X_START);
  assign load_y = set_valid && (win_sel_e'(set_sel) == SEL_Y_START);

  win_bounds #(.X_BITS(X_BITS), .Y_LINES(Y_LINES)) u_bounds (
    .clk(clk), .rst_n(rst_n_int), .set_valid(set_valid), .set_sel(set_sel),
    .set_data(set_data), .clamp_x(clamp_x), .clamp_y(clamp_y),
    .x_start(x_start), .x_end(x_end), .y_start(y_start), .y_end(y_end)
  );

  win_dummy_ctl u_dummy (
    .clk(clk), .rst_n(rst_n_int), .set_valid(set_valid), .acc_valid(acc_valid),
    .acc_read(acc_read), .step(step), .rd_valid(rd_valid)
  );

  win_cursor #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_cursor (
    .clk(clk), .rst_n(rst_n_int), .load_x(load_x), .load_y(load_y),
    .load_x_val(clamp_x), .load_y_val(clamp_y), .step(step),
    .x_start(x_start), .x_end(x_end), .y_start(y_start), .y_end(y_end),
    .x_q(cur_x), .y_q(cur_y)
  );

  always_comb begin
    ram_col = col_reverse ? (X_BITS'(XMAX) - cur_x) : cur_x;
  end

  a_r7_mirror_sum: assert property (@(posedge clk) disable iff (!rst_n_int)
    col_reverse |-> (ram_col + cur_x == X_BITS'(XMAX)));
  a_r2_start_load_moves: assert property (@(posedge clk) disable iff (!rst_n_int)
    load_x |=> (cur_x == x_start));
endmodule

// File: tb/tb_win_addr_gen.sv
module tb_win_addr_gen;
  localparam int XB = 4;
  localparam int YL = 10;
  localparam int YB = $clog2(YL);
  localparam int DW = (XB > YB) ? XB : YB;

  logic clk = 1'b0;
  logic rst_n;
  logic set_valid, acc_valid, acc_read, col_reverse;
  logic [1:0] set_sel;
  logic [DW-1:0] set_data;
  logic [XB-1:0] cur_x, ram_col;
  logic [YB-1:0] cur_y;
  logic rd_valid;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  win_addr_gen #(.X_BITS(XB), .Y_LINES(YL)) dut (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_sel(set_sel),
    .set_data(set_data), .acc_valid(acc_valid), .acc_read(acc_read),
    .col_reverse(col_reverse), .cur_x(cur_x), .cur_y(cur_y),
    .ram_col(ram_col), .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int sel, input int val);
    set_valid = 1'b1; set_sel = 2'(sel); set_data = DW'(val);
    @(negedge clk);
    set_valid = 1'b0;
  endtask

  task automatic access(input bit rd);
    acc_valid = 1'b1; acc_read = rd;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 x after reset", cur_x, 0);
    chk("R1 y after reset", cur_y, 0);
    access(1'b1);
    chk("R1 dummy after reset rd_valid", rd_valid, 0);
    chk("R8 dummy no advance", cur_x, 0);
    access(1'b1);
    chk("R8 real read rd_valid", rd_valid, 1);
    chk("R8 real read advance", cur_x, 1);
  endtask

  task automatic t_full_wrap;
    for (int i = 0; i < 14; i++) access(1'b0);
    chk("R4 x at full end", cur_x, 15);
    chk("R9 write rd_valid", rd_valid, 0);
    access(1'b0);
    chk("R5 x wraps to 0", cur_x, 0);
    chk("R5 y steps", cur_y, 1);
  endtask

  task automatic t_window;
    load(0, 3);
    chk("R2 x start moves cursor", cur_x, 3);
    load(1, 5);
    load(2, 7);
    chk("R2 y start moves cursor", cur_y, 7);
    load(3, 8);
    chk("R3 end load keeps x", cur_x, 3);
    chk("R3 end load keeps y", cur_y, 7);
    access(1'b0); access(1'b0);
    chk("R4 x inside window", cur_x, 5);
    access(1'b0);
    chk("R5 x back to start", cur_x, 3);
    chk("R5 y to 8", cur_y, 8);
    access(1'b0); access(1'b0); access(1'b0);
    chk("R6 x wrap", cur_x, 3);
    chk("R6 y back to start", cur_y, 7);
  endtask

  task automatic t_clamp_reverse;
    load(0, 14);
    load(1, 15);
    load(2, 12);
    chk("R2 y start clamped", cur_y, 9);
    load(3, 13);
    access(1'b0);
    chk("R4 x to 15", cur_x, 15);
    col_reverse = 1'b1;
    #1;
    chk("R7 mirrored col", ram_col, 0);
    access(1'b0);
    chk("R6 y end clamped wraps", cur_y, 9);
    chk("R5 x to 14", cur_x, 14);
    chk("R7 mirrored col 14", ram_col, 1);
    col_reverse = 1'b0;
    #1;
    chk("R7 plain col", ram_col, 14);
  endtask

  task automatic t_dummy_write;
    load(2, 0);
    load(3, 9);
    load(0, 2);
    access(1'b0);
    chk("R9 write advances while armed", cur_x, 3);
    access(1'b1);
    chk("R9 write left flag armed", rd_valid, 0);
    chk("R8 dummy hold x", cur_x, 3);
    access(1'b1);
    chk("R8 read valid", rd_valid, 1);
    chk("R8 read advance", cur_x, 4);
  endtask

  task automatic t_priority;
    set_valid = 1'b1; set_sel = 2'd1; set_data = DW'(15);
    acc_valid = 1'b1; acc_read = 1'b0;
    @(negedge clk);
    set_valid = 1'b0; acc_valid = 1'b0;
    chk("R10 access ignored on load", cur_x, 4);
    access(1'b1);
    chk("R10 load re-armed dummy", rd_valid, 0);
    chk("R10 dummy holds x", cur_x, 4);
  endtask

  initial begin
    rst_n = 1'b0; set_valid = 1'b0; set_sel = '0; set_data = '0;
    acc_valid = 1'b0; acc_read = 1'b0; col_reverse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_wrap();
    t_window();
    t_clamp_reverse();
    t_dummy_write();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule